// File: doc/BRIEF.md
# Programmable binary one-shot timer

A sixteen-stage binary counter, advanced by a clock enable, with a four-way tap select that picks the output stage. It works either as a free-running frequency divider or as a single-cycle timer. In divider mode the chosen stage reaches the output through a polarity control, which gives a square wave. In single-cycle mode the output flips after half the selected count and then stays at that level until the block is re-armed.

The counter is built as two eight-stage halves. For one select code the upper half is clocked directly by every enabled tick, so the lower half is bypassed. A master clear, a gated automatic clear and any change of the mode level each clear the counter and the output latch. While a clear is active, counting stops and the output shows the polarity level. All controls are sampled on the clock. The asynchronous active-low reset stands for the power-up initialisation.

Top module: `tap_timer`

## Requirements
- R1: The counter advances by exactly one for each rising clock edge with `tick_en` high, and holds when `tick_en` is low.
- R2: Select code {`sel_a`,`sel_b`} picks the stage length 2^n: 00 gives n=13, 01 gives n=10, 10 gives n=8, 11 gives n=16. With `sel_a`=1 the top (16th) stage is the tapped stage.
- R3: With `sel_a`=1 and `sel_b`=0 the upper eight stages advance on every enabled tick, bypassing the lower eight, so the effective length is 2^8.
- R4: `mst_clr` high clears every counter stage and the output latch at the next edge, whatever the count. While a clear is active the counter does not advance, even with `tick_en` high.
- R5: `auto_clr_req` clears the block like `mst_clr` only while `auto_clr_off` is low. When `auto_clr_off` is high the request has no effect.
- R6: While any clear is active (master, enabled auto, or mode change), `q` equals `inv_sel`.
- R7: With `recycle`=1, `q` = `inv_sel` XOR stage n, a square wave of period 2^n enabled ticks that starts at the `inv_sel` level.
- R8: With `recycle`=0, `q` first leaves the `inv_sel` level when the count since the clear reaches 2^(n-1), and then holds the inverted level for all later ticks.
- R9: A change of the `recycle` level produces a one-cycle clear of the counter and latch, and this re-arms a single-cycle run.
- R10: A clear wins over an enabled tick that arrives in the same cycle, and no count is kept from that tick.
- R11: While `rst_n` is low the counter and latch are zero and `q` equals `inv_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Count enable, one count per enabled edge |
| mst_clr | input | 1 | Master clear, active high |
| auto_clr_req | input | 1 | Automatic clear request, active high |
| auto_clr_off | input | 1 | High disables the automatic clear request |
| sel_a | input | 1 | Tap select, upper bit |
| sel_b | input | 1 | Tap select, lower bit |
| recycle | input | 1 | 1 = divider mode, 0 = single-cycle mode |
| inv_sel | input | 1 | Output polarity and idle level |
| q | output | 1 | Timer output |

## Verification
A clear and the tick that would set the single-cycle latch can land on the same edge. The bench counts to one short of half the 2^10 length, then raises `mst_clr` in the same cycle as an enabled tick. It judges the result by `q` staying at the idle level, and by needing a full fresh 512 ticks afterwards before it flips. A mode-level change that arrives while a latched run is holding is also provoked. It must force the idle level at once and restart the count from zero, which shows in when the later recycle toggle occurs.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
  // Counter geometry: two halves, lower one may be bypassed.
  localparam int unsigned LO_STAGES = 8;
  localparam int unsigned HI_STAGES = 8;
  localparam int unsigned STAGES    = LO_STAGES + HI_STAGES;

  // Stage lengths (2^n) per select code.
  localparam int unsigned LEN_SEL00 = 13;
  localparam int unsigned LEN_SEL01 = 10;
  localparam int unsigned LEN_SEL1X = STAGES;

  typedef logic [STAGES-1:0] count_t;

  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_SHORT = 2'b01,
    SEL_BYP   = 2'b10,
    SEL_FULL  = 2'b11
  } tap_sel_e;
endpackage

// File: rtl/tt_clear_ctrl.sv
module tt_clear_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mst_clr,
  input  logic auto_clr_req,
  input  logic auto_clr_off,
  input  logic recycle,
  output logic clr_all
);
  logic mode_q;
  logic mode_d;
  logic mode_chg;

  always_comb begin
    mode_d   = recycle;
    mode_chg = recycle ^ mode_q;
    clr_all  = mst_clr | (auto_clr_req & ~auto_clr_off) | mode_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tap_timer_pkg::*;
#(
  parameter int unsigned LO_W = LO_STAGES,
  parameter int unsigned HI_W = HI_STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 tick_en,
  input  logic                 bypass,
  output logic [LO_W+HI_W-1:0] cnt
);
  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            lo_carry;
  logic            hi_step;

  always_comb begin
    lo_carry = &lo_q;
    hi_step  = tick_en & (bypass | lo_carry);
    lo_d     = lo_q;
    hi_d     = hi_q;
    if (clr) begin
      lo_d = '0;
      hi_d = '0;
    end else begin
      if (tick_en) lo_d = lo_q + 1'b1;
      if (hi_step) hi_d = hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt = {hi_q, lo_q};
endmodule

// File: rtl/tt_out_stage.sv
module tt_out_stage
  import tap_timer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  count_t cnt,
  input  logic   sel_a,
  input  logic   sel_b,
  input  logic   recycle,
  input  logic   inv_sel,
  output logic   latch,
  output logic   q
);
  localparam int unsigned TAP_L = LEN_SEL00 - 1;
  localparam int unsigned TAP_S = LEN_SEL01 - 1;
  localparam int unsigned TAP_F = LEN_SEL1X - 1;

  tap_sel_e sel;
  logic     tap;
  logic     latch_q, latch_d;
  logic     level;

  always_comb begin
    sel = tap_sel_e'({sel_a, sel_b});
    unique case (sel)
      SEL_LONG:  tap = cnt[TAP_L];
      SEL_SHORT: tap = cnt[TAP_S];
      default:   tap = cnt[TAP_F];
    endcase
    latch_d = clr ? 1'b0 : (latch_q | tap);
    level   = recycle ? tap : (latch_q | tap);
    q       = inv_sel ^ (~clr & level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= latch_d;
  end

  assign latch = latch_q;
endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic mst_clr,
  input  logic auto_clr_req,
  input  logic auto_clr_off,
  input  logic sel_a,
  input  logic sel_b,
  input  logic recycle,
  input  logic inv_sel,
  output logic q
);
  logic   clr_all;
  logic   bypass;
  logic   latch_w;
  count_t cnt_w;

  assign bypass = sel_a & ~sel_b;

  tt_clear_ctrl u_clr (
    .clk          (clk),
    .rst_n        (rst_n),
    .mst_clr      (mst_clr),
    .auto_clr_req (auto_clr_req),
    .auto_clr_off (auto_clr_off),
    .recycle      (recycle),
    .clr_all      (clr_all)
  );

  tt_counter #(.LO_W(LO_STAGES), .HI_W(HI_STAGES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_all),
    .tick_en (tick_en),
    .bypass  (bypass),
    .cnt     (cnt_w)
  );

  tt_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_all),
    .cnt     (cnt_w),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .recycle (recycle),
    .inv_sel (inv_sel),
    .latch   (latch_w),
    .q       (q)
  );
endmodule

// File: rtl/tap_timer_chk.sv
module tap_timer_chk
  import tap_timer_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   clr,
  input logic   tick_en,
  input count_t cnt,
  input logic   latch,
  input logic   q,
  input logic   pol
);
  // R6: idle level during any clear
  assert_clear_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (q == pol));

  // R4: clear empties counter and latch
  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0) && !latch);

  // R1: no enable, no clear -> count holds
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick_en) |=> $stable(cnt));

  // R1: lower half steps by one per enabled tick
  assert_lo_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick_en) |=> (cnt[LO_STAGES-1:0] == $past(cnt[LO_STAGES-1:0]) + 1'b1));

  // R8: once set, the latch stays set until a clear
  assert_latch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !clr) |=> latch);
endmodule

bind tap_timer tap_timer_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr     (clr_all),
  .tick_en (tick_en),
  .cnt     (cnt_w),
  .latch   (latch_w),
  .q       (q),
  .pol     (inv_sel)
);

// File: tb/tap_timer_tb.sv
module tap_timer_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;
  localparam int  NVEC       = 16;

  // {sel_a, sel_b, recycle, inv_sel, ticks[16:0], expected q}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0,1'b1,1'b0,1'b0,17'd511,  1'b0},  // R8 n=10 one short
    {1'b0,1'b1,1'b0,1'b0,17'd512,  1'b1},  // R8 n=10 flips
    {1'b0,1'b1,1'b0,1'b1,17'd512,  1'b0},  // R8 inverted polarity
    {1'b0,1'b1,1'b1,1'b0,17'd1124, 1'b0},  // R7 n=10
    {1'b0,1'b1,1'b1,1'b0,17'd1536, 1'b1},  // R7 n=10
    {1'b1,1'b0,1'b0,1'b0,17'd127,  1'b0},  // R3 bypass one short
    {1'b1,1'b0,1'b0,1'b0,17'd128,  1'b1},  // R3 bypass flips
    {1'b1,1'b0,1'b1,1'b1,17'd256,  1'b1},  // R3 bypass recycle
    {1'b1,1'b0,1'b1,1'b1,17'd200,  1'b0},  // R3 bypass recycle
    {1'b0,1'b0,1'b0,1'b0,17'd4095, 1'b0},  // R2 n=13 one short
    {1'b0,1'b0,1'b0,1'b0,17'd4096, 1'b1},  // R2 n=13 flips
    {1'b0,1'b0,1'b1,1'b1,17'd8192, 1'b1},  // R2 n=13 recycle period
    {1'b1,1'b1,1'b0,1'b0,17'd1000, 1'b0},  // R2 n=16 no bypass
    {1'b1,1'b1,1'b0,1'b0,17'd32768,1'b1},  // R2 n=16 flips
    {1'b0,1'b1,1'b0,1'b0,17'd1023, 1'b1},  // R8 holds after flip
    {1'b0,1'b0,1'b1,1'b0,17'd6144, 1'b1}   // R7 n=13 second half
  };

  logic clk, rst_n, tick_en, mst_clr, auto_clr_req, auto_clr_off;
  logic sel_a, sel_b, recycle, inv_sel, q;
  int   checks, errors;
  bit   done;

  tap_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mst_clr(mst_clr),
    .auto_clr_req(auto_clr_req), .auto_clr_off(auto_clr_off),
    .sel_a(sel_a), .sel_b(sel_b), .recycle(recycle), .inv_sel(inv_sel), .q(q)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: q=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // called at a negedge; leaves at a negedge with tick_en low
  task automatic run_ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    #1;
  endtask

  task automatic start(input logic a, input logic b, input logic rec, input logic pol);
    sel_a = a; sel_b = b; recycle = rec; inv_sel = pol;
    mst_clr = 1'b1; tick_en = 1'b0;
    @(negedge clk);
    mst_clr = 1'b0;
  endtask

  initial begin
    if (WATCHDOG > 0) begin
      repeat (WATCHDOG) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; mst_clr = 1'b0;
    auto_clr_req = 1'b0; auto_clr_off = 1'b1;
    sel_a = 1'b0; sel_b = 1'b1; recycle = 1'b0; inv_sel = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R11 reset level pol=1", q, 1'b1);
    inv_sel = 1'b0;
    #1 check("R11 reset level pol=0", q, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R2 R3 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      start(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18]);
      run_ticks(int'(VEC[i][17:1]));
      check($sformatf("R2/R7/R8 vector %0d", i), q, VEC[i][0]);
    end

    // R4: clear held with enable high inhibits counting
    sel_a = 1'b0; sel_b = 1'b1; recycle = 1'b0; inv_sel = 1'b0;
    mst_clr = 1'b1; tick_en = 1'b1;
    repeat (600) @(negedge clk);
    #1 check("R6 level while clear held", q, 1'b0);
    mst_clr = 1'b0; tick_en = 1'b0;
    run_ticks(511);
    check("R4 no count during clear", q, 1'b0);
    run_ticks(1);
    check("R4 count from zero after clear", q, 1'b1);

    // R10: clear and tick in the same cycle
    start(1'b0, 1'b1, 1'b0, 1'b0);
    run_ticks(511);
    mst_clr = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    mst_clr = 1'b0; tick_en = 1'b0;
    #1 check("R10 clear beats tick", q, 1'b0);
    run_ticks(511);
    check("R10 full restart one short", q, 1'b0);
    run_ticks(1);
    check("R10 full restart flips", q, 1'b1);

    // R5: automatic clear gated by auto_clr_off (latched q=1 now)
    auto_clr_off = 1'b1; auto_clr_req = 1'b1;
    #1 check("R5 request ignored while off (same cycle)", q, 1'b1);
    @(negedge clk);
    auto_clr_req = 1'b0;
    #1 check("R5 request ignored while off", q, 1'b1);
    auto_clr_off = 1'b0; auto_clr_req = 1'b1;
    #1 check("R6 level during auto clear", q, 1'b0);
    @(negedge clk);
    auto_clr_req = 1'b0;
    #1 check("R5 auto clear re-arms", q, 1'b0);
    run_ticks(512);
    check("R5 count after auto clear", q, 1'b1);
    auto_clr_off = 1'b1;

    // R9: mode change clears and re-arms
    recycle = 1'b1;
    #1 check("R9 mode change forces idle", q, 1'b0);
    @(negedge clk);
    #1 check("R9 cleared after mode change", q, 1'b0);
    run_ticks(511);
    check("R9 recycle restarts from zero", q, 1'b0);
    run_ticks(1);
    check("R7 recycle toggles at 2^(n-1)", q, 1'b1);
    recycle = 1'b0;
    #1 check("R9 back to single forces idle", q, 1'b0);
    @(negedge clk);
    run_ticks(512);
    check("R9 single run re-armed", q, 1'b1);

    // R1: enable low holds the count
    start(1'b1, 1'b0, 1'b1, 1'b0);
    run_ticks(100);
    repeat (200) @(negedge clk);
    run_ticks(27);
    check("R1 hold with enable low", q, 1'b0);
    run_ticks(1);
    check("R1 count resumes", q, 1'b1);

    summary();
  end
endmodule